// File: doc/BRIEF.md
# Subpixel Eight-Tap Horizontal Interpolator

This block builds motion-compensated prediction rows for a block eight pixels wide. For each row it takes a 15-pixel window of 8-bit reference samples and computes eight output pixels. Each output is an eight-tap weighted sum centred on its position, using one coefficient set picked by a filter type and a fractional phase. The sum is rounded, scaled down by 128 and saturated to the 8-bit pixel range. Every pixel is computed on every row. No output is skipped because of the data.

Software, or an upstream loader, first fills the coefficient bank through a write port. The bank holds three filter types, each with sixteen phases of eight signed 16-bit taps. A start pulse then programs the row count, the type and the phase. The block accepts exactly that many windows through a valid/ready input and returns the same number of filtered rows through a valid/ready output, in arrival order. A one-cycle done pulse marks the end of the block.

Top module: `subpel_hfilt8`

## Requirements
- R1: Output pixel j (0..7, at `out_pix[8j+7:8j]`) is formed from window bytes j..j+7, where window byte i sits at `in_pix[8i+7:8i]` and is multiplied by tap i−j. Tap 3 therefore weights the pixel at the output position, and taps 0..2 and 4..7 weight the three pixels to its left and the four to its right.
- R2: The signed sum of the eight products plus 64 is shifted right arithmetically by 7 bits, so the result is floor((sum+64)/128).
- R3: A shifted result below 0 is output as 0, and one above 255 is output as 255.
- R4: A coefficient is written with `cfg_we` high at address {type[8:7], phase[6:3], tap[2:0]} as a signed 16-bit value. The type and phase latched at start select the eight taps used for the whole block.
- R5: A coefficient write presented while `busy` is high changes neither that block's results nor the stored table.
- R6: A start is taken only when `busy` is low, `start_rows` is nonzero and `start_type` is 0..2, and `busy` is high from the next cycle. A start that fails any of these conditions is ignored.
- R7: `in_ready` is high only while rows of the current block remain to be accepted and the output register is empty or is handing over its row in the same cycle. Exactly `start_rows` windows are accepted per block.
- R8: `out_valid` is high in the cycle after a window is accepted. While `out_ready` is low, `out_valid` and `out_pix` hold steady.
- R9: Output rows leave in the order their windows were accepted.
- R10: `done` is a one-cycle pulse in the cycle after the last row's output handshake. `busy` falls in that same cycle.
- R11: After reset, `busy`, `done`, `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 9 | Coefficient address {type, phase, tap} |
| cfg_data | input | 16 | Signed coefficient value |
| start | input | 1 | Begin a block |
| start_rows | input | 8 | Row count of the block |
| start_phase | input | 4 | Fractional phase select |
| start_type | input | 2 | Filter type select (0..2) |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle end-of-block pulse |
| in_valid | input | 1 | Source window valid |
| in_ready | output | 1 | Source window accepted when high with in_valid |
| in_pix | input | 120 | Fifteen source pixels, byte i = position i−3 relative to output 0 |
| out_valid | output | 1 | Filtered row valid |
| out_ready | input | 1 | Downstream takes the row |
| out_pix | output | 64 | Eight filtered pixels |

## Verification
A start makes `busy` visible one cycle later. The filtered row appears one cycle after the edge that accepted its window, and `done` appears one cycle after the edge that hands over the last row. The bench therefore changes inputs on the falling clock edge and samples on the falling edge that follows the relevant rising edge. This places each check exactly one register stage after its stimulus. Under backpressure, the bench samples the held row on several successive falling edges before it releases `out_ready`.

// File: rtl/subpel_pkg.sv
package subpel_pkg;
  localparam int PIX_W     = 8;
  localparam int COEF_W    = 16;
  localparam int TAPS      = 8;
  localparam int OUT_PIX   = 8;
  localparam int PHASES    = 16;
  localparam int TYPES     = 3;
  localparam int ROW_W     = 8;
  localparam int RND_SHIFT = 7;

  localparam int WIN_PIX   = OUT_PIX + TAPS - 1;
  localparam int TAP_AW    = $clog2(TAPS);
  localparam int PH_AW     = $clog2(PHASES);
  localparam int TY_AW     = $clog2(TYPES);
  localparam int ADDR_W    = TY_AW + PH_AW + TAP_AW;
  localparam int ACC_W     = COEF_W + PIX_W + 1 + TAP_AW;
  localparam int PIX_MAX   = (1 << PIX_W) - 1;
  localparam int RND_BIAS  = 1 << (RND_SHIFT - 1);
endpackage

// File: rtl/subpel_coef_bank.sv
module subpel_coef_bank
  import subpel_pkg::*;
(
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [COEF_W-1:0]        wr_data,
  input  logic [TY_AW-1:0]         sel_type,
  input  logic [PH_AW-1:0]         sel_phase,
  output logic [TAPS*COEF_W-1:0]   coef_o
);
  localparam int DEPTH = TYPES * PHASES * TAPS;

  logic [COEF_W-1:0] tbl_q [DEPTH];
  logic              wr_ok;

  assign wr_ok = wr_en && (wr_addr < ADDR_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_ok) tbl_q[wr_addr] <= wr_data;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_rd
    assign coef_o[k*COEF_W +: COEF_W] = tbl_q[{sel_type, sel_phase, TAP_AW'(k)}];
  end
endmodule

// File: rtl/subpel_tap8.sv
module subpel_tap8
  import subpel_pkg::*;
(
  input  logic [TAPS*PIX_W-1:0]  win_i,
  input  logic [TAPS*COEF_W-1:0] coef_i,
  output logic [PIX_W-1:0]       pix_o
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] scaled;

  always_comb begin
    acc = ACC_W'(RND_BIAS);
    for (int k = 0; k < TAPS; k++) begin
      acc += ACC_W'($signed(coef_i[k*COEF_W +: COEF_W])) *
             ACC_W'($signed({1'b0, win_i[k*PIX_W +: PIX_W]}));
    end
    scaled = acc >>> RND_SHIFT;
    if (scaled < 0)                          pix_o = '0;
    else if (scaled > ACC_W'(PIX_MAX))       pix_o = '1;
    else                                     pix_o = scaled[PIX_W-1:0];
  end
endmodule

// File: rtl/subpel_row_ctrl.sv
module subpel_row_ctrl
  import subpel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  start_rows,
  input  logic [TY_AW-1:0]  start_type,
  input  logic [PH_AW-1:0]  start_phase,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              in_fire,
  output logic              out_valid,
  output logic              busy,
  output logic              done,
  output logic [TY_AW-1:0]  type_q,
  output logic [PH_AW-1:0]  phase_q
);
  logic [ROW_W-1:0] in_left_q, in_left_d, out_left_q, out_left_d;
  logic             out_valid_q, out_valid_d, done_q, done_d;
  logic [TY_AW-1:0] type_d;
  logic [PH_AW-1:0] phase_d;
  logic             start_ok, out_fire;

  assign busy      = (out_left_q != '0);
  assign start_ok  = start && !busy && (start_rows != '0) && (start_type < TY_AW'(TYPES));
  assign in_ready  = (in_left_q != '0) && (!out_valid_q || out_ready);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid_q && out_ready;
  assign out_valid = out_valid_q;
  assign done      = done_q;

  always_comb begin
    in_left_d   = in_left_q;
    out_left_d  = out_left_q;
    type_d      = type_q;
    phase_d     = phase_q;
    out_valid_d = out_valid_q;
    if (start_ok) begin
      in_left_d  = start_rows;
      out_left_d = start_rows;
      type_d     = start_type;
      phase_d    = start_phase;
    end else begin
      if (in_fire)  in_left_d  = in_left_q - ROW_W'(1);
      if (out_fire) out_left_d = out_left_q - ROW_W'(1);
    end
    if (in_fire)       out_valid_d = 1'b1;
    else if (out_fire) out_valid_d = 1'b0;
    done_d = out_fire && (out_left_q == ROW_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_left_q   <= '0;
      out_left_q  <= '0;
      type_q      <= '0;
      phase_q     <= '0;
      out_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      in_left_q   <= in_left_d;
      out_left_q  <= out_left_d;
      type_q      <= type_d;
      phase_q     <= phase_d;
      out_valid_q <= out_valid_d;
      done_q      <= done_d;
    end
  end

  assert_accept_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_left_q <= out_left_q);
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && !out_ready) |=> out_valid_q);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(type_q) && $stable(phase_q)));
endmodule

// File: rtl/subpel_hfilt8.sv
module subpel_hfilt8
  import subpel_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [COEF_W-1:0]         cfg_data,
  input  logic                      start,
  input  logic [ROW_W-1:0]          start_rows,
  input  logic [PH_AW-1:0]          start_phase,
  input  logic [TY_AW-1:0]          start_type,
  output logic                      busy,
  output logic                      done,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [WIN_PIX*PIX_W-1:0]  in_pix,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [OUT_PIX*PIX_W-1:0]  out_pix
);
  logic [TY_AW-1:0]           type_q;
  logic [PH_AW-1:0]           phase_q;
  logic                       in_fire;
  logic [TAPS*COEF_W-1:0]     coef_sel;
  logic [OUT_PIX*PIX_W-1:0]   pix_d, pix_q;

  subpel_row_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_rows (start_rows),
    .start_type (start_type),
    .start_phase(start_phase),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .in_fire    (in_fire),
    .out_valid  (out_valid),
    .busy       (busy),
    .done       (done),
    .type_q     (type_q),
    .phase_q    (phase_q)
  );

  subpel_coef_bank u_bank (
    .clk      (clk),
    .wr_en    (cfg_we && !busy),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_data),
    .sel_type (type_q),
    .sel_phase(phase_q),
    .coef_o   (coef_sel)
  );

  for (genvar j = 0; j < OUT_PIX; j++) begin : g_pix
    subpel_tap8 u_tap (
      .win_i (in_pix[j*PIX_W +: TAPS*PIX_W]),
      .coef_i(coef_sel),
      .pix_o (pix_d[j*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk) begin
    if (in_fire) pix_q <= pix_d;
  end

  assign out_pix = pix_q;

  assert_row_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_pix));
  assert_coef_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(coef_sel));
endmodule

// File: tb/subpel_hfilt8_tb.sv
module subpel_hfilt8_tb_top;
  logic         clk, rst_n;
  logic         cfg_we;
  logic [8:0]   cfg_addr;
  logic [15:0]  cfg_data;
  logic         start;
  logic [7:0]   start_rows;
  logic [3:0]   start_phase;
  logic [1:0]   start_type;
  logic         busy, done, in_valid, in_ready, out_valid, out_ready;
  logic [119:0] in_pix;
  logic [63:0]  out_pix;

  int checks = 0;
  int failures = 0;
  int cf [3][16][8];

  subpel_hfilt8 dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam int VEC [0:5][0:4] = '{
    '{0, 0, 3, 10, 17},
    '{1, 7, 4, 200, 3},
    '{2, 15, 2, 0, 255},
    '{0, 9, 5, 128, 41},
    '{1, 1, 1, 255, 0},
    '{2, 4, 3, 77, 129}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int model_pix(int t, int p, logic [119:0] w, int j);
    int s = 64;
    for (int k = 0; k < 8; k++) s += cf[t][p][k] * int'(w[8*(j+k) +: 8]);
    s = s >>> 7;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic logic [119:0] mkwin(int base, int step, int r);
    logic [119:0] w;
    for (int i = 0; i < 15; i++) w[8*i +: 8] = 8'(base + step*i + r*31);
    return w;
  endfunction

  task automatic wr_coef(input int t, input int p, input int k, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {2'(t), 4'(p), 3'(k)}; cfg_data = 16'(v);
    cf[t][p][k] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_taps(input int t, input int p, input int c0, input int c1,
                          input int c2, input int c3, input int c4, input int c5,
                          input int c6, input int c7);
    int c [8];
    c = '{c0, c1, c2, c3, c4, c5, c6, c7};
    for (int k = 0; k < 8; k++) wr_coef(t, p, k, c[k]);
  endtask

  task automatic do_start(input int t, input int p, input int rows);
    @(negedge clk);
    start = 1'b1; start_type = 2'(t); start_phase = 4'(p); start_rows = 8'(rows);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R6 busy after start", busy, 1);
  endtask

  // Block of rows from a generated pattern; interfere=1 adds a write and a start while busy (R5, R6)
  task automatic run_block(input int t, input int p, input int rows,
                           input int base, input int step, input bit interfere);
    logic [119:0] w;
    do_start(t, p, rows);
    if (interfere) begin
      cfg_we = 1'b1; cfg_addr = {2'(t), 4'(p), 3'd3}; cfg_data = 16'h0000;
      start = 1'b1; start_type = 2'((t + 1) % 3); start_phase = 4'(p + 3); start_rows = 8'd9;
      @(negedge clk);
      cfg_we = 1'b0; start = 1'b0;
    end
    for (int r = 0; r < rows; r++) begin
      w = mkwin(base, step, r);
      in_valid = 1'b1; in_pix = w;
      chk(in_ready == 1'b1, "R7 ready while rows remain", in_ready, 1);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R8 valid one cycle after accept", out_valid, 1);
      for (int j = 0; j < 8; j++)
        chk(int'(out_pix[8*j +: 8]) == model_pix(t, p, w, j), "R1/R2/R3/R9 pixel",
            int'(out_pix[8*j +: 8]), model_pix(t, p, w, j));
      chk(done == 1'b0, "R10 no early done", done, 0);
    end
    chk(in_ready == 1'b0, "R7 no ready after last row", in_ready, 0);
    @(negedge clk);
    chk(done == 1'b1, "R10 done pulse", done, 1);
    chk(busy == 1'b0, "R10 busy falls", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", done, 0);
  endtask

  task automatic run_hand(input int t, input int p, input logic [119:0] w,
                          input logic [63:0] exp, input string req);
    do_start(t, p, 1);
    in_valid = 1'b1; in_pix = w;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, req, out_valid, 1);
    for (int j = 0; j < 8; j++)
      chk(out_pix[8*j +: 8] == exp[8*j +: 8], req, int'(out_pix[8*j +: 8]), int'(exp[8*j +: 8]));
    @(negedge clk);
    chk(done == 1'b1, "R10 done after single row", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [119:0] w;
    logic [63:0]  held;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0; start = 1'b0;
    start_rows = '0; start_phase = '0; start_type = '0; in_valid = 1'b0;
    in_pix = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(busy == 1'b0, "R11 busy", busy, 0);
    chk(done == 1'b0, "R11 done", done, 0);
    chk(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
    chk(in_ready == 1'b0, "R11 in_ready", in_ready, 0);

    // R4 load whole table
    for (int t = 0; t < 3; t++)
      for (int p = 0; p < 16; p++)
        for (int k = 0; k < 8; k++) begin
          cfg_we = 1'b1; cfg_addr = {2'(t), 4'(p), 3'(k)};
          cf[t][p][k] = ((t*53 + p*29 + k*17) % 97) - 30;
          cfg_data = 16'(cf[t][p][k]);
          @(negedge clk);
        end
    cfg_we = 1'b0;

    // vector table walk: R1 R2 R3 R4 R9
    for (int v = 0; v < 6; v++)
      run_block(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1'b0);

    // R1 tap alignment: identity set puts window byte j+3 on output j
    set_taps(2, 15, 0, 0, 0, 128, 0, 0, 0, 0);
    for (int i = 0; i < 15; i++) w[8*i +: 8] = 8'(i*10 + 1);
    run_hand(2, 15, w, {8'd101, 8'd91, 8'd81, 8'd71, 8'd61, 8'd51, 8'd41, 8'd31}, "R1 alignment");

    // R2 rounding with unit tap
    set_taps(1, 5, 0, 0, 0, 1, 0, 0, 0, 0);
    w = '0;
    w[8*3 +: 64] = {8'd128, 8'd127, 8'd0, 8'd255, 8'd192, 8'd191, 8'd64, 8'd63};
    run_hand(1, 5, w, {8'd1, 8'd1, 8'd0, 8'd2, 8'd2, 8'd1, 8'd1, 8'd0}, "R2 rounding");

    // R3 high saturation
    set_taps(1, 3, 0, 0, 0, 300, 0, 0, 0, 0);
    w = '0;
    w[8*3 +: 64] = {8'd200, 8'd255, 8'd110, 8'd109, 8'd55, 8'd50, 8'd1, 8'd0};
    run_hand(1, 3, w, {8'd255, 8'd255, 8'd255, 8'd255, 8'd129, 8'd117, 8'd2, 8'd0}, "R3 clip high");

    // R3 low saturation on negative sums
    set_taps(0, 2, 0, 0, 0, -128, 128, 0, 0, 0);
    w = '0;
    w[8*3 +: 72] = {8'd6, 8'd5, 8'd100, 8'd255, 8'd0, 8'd20, 8'd20, 8'd30, 8'd10};
    run_hand(0, 2, w, {8'd1, 8'd0, 8'd0, 8'd255, 8'd0, 8'd0, 8'd0, 8'd20}, "R3 clip low");

    // R5 write during block ignored; R6 start during block ignored
    run_block(2, 15, 2, 5, 9, 1'b1);
    for (int i = 0; i < 15; i++) w[8*i +: 8] = 8'(i*10 + 1);
    run_hand(2, 15, w, {8'd101, 8'd91, 8'd81, 8'd71, 8'd61, 8'd51, 8'd41, 8'd31}, "R5 table unchanged");

    // R6 ignored starts: zero rows and type code 3
    @(negedge clk);
    start = 1'b1; start_rows = 8'd0; start_type = 2'd0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R6 zero rows ignored", busy, 0);
    start = 1'b1; start_rows = 8'd2; start_type = 2'd3;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R6 type 3 ignored", busy, 0);
    chk(in_ready == 1'b0, "R6 no ready after ignored start", in_ready, 0);

    // R7 R8 R9 backpressure with identity set
    out_ready = 1'b0;
    do_start(2, 15, 2);
    for (int i = 0; i < 15; i++) w[8*i +: 8] = 8'(i + 40);
    in_valid = 1'b1; in_pix = w;
    @(negedge clk);
    for (int i = 0; i < 15; i++) w[8*i +: 8] = 8'(i*3 + 150);
    in_pix = w;
    chk(out_valid == 1'b1, "R8 valid under stall", out_valid, 1);
    chk(out_pix[7:0] == 8'd43, "R9 first row first", int'(out_pix[7:0]), 43);
    chk(in_ready == 1'b0, "R7 ready low while output full", in_ready, 1'b0);
    held = out_pix;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
      chk(out_pix == held, "R8 data held", int'(out_pix[7:0]), int'(held[7:0]));
      chk(in_ready == 1'b0, "R7 ready held low", in_ready, 0);
    end
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R7 ready when output drains", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R8 second row valid", out_valid, 1);
    chk(out_pix[7:0] == 8'd159, "R9 second row order", int'(out_pix[7:0]), 159);
    chk(out_pix[63:56] == 8'd180, "R1 second row last pixel", int'(out_pix[63:56]), 180);
    @(negedge clk);
    chk(done == 1'b1, "R10 done after stall", done, 1);
    chk(out_valid == 1'b0, "R8 valid clears after handover", out_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule